// File: doc/BRIEF.md
# Serial Flash Command Guard

This block sits behind the serial port of a small non-volatile memory and decides which commands may reach the array. While chip select is low it counts serial bits, captures the first byte as the opcode and the second byte as the status payload. When chip select rises it checks the frame against the current protection state. An accepted modifying command produces a one-cycle execute strobe with a command code. The block holds a write-arm latch, a busy flag driven by a per-operation down-counter, a two-bit guard level, a status-lock bit and a sleep state. It also combines the status lock with an active-low write-protect pin.

The serial clock is not used as a clock here. The system clock samples the port, and `bit_en` marks each serial bit in which `sdi` is valid. The read-status command returns the status byte on `sdo`, most significant bit first. The byte is reloaded after every eighth bit, so a long read repeats the live status. The same byte is also available in parallel on `status`. Only the command decision is modelled. The array and the real program and erase timing are not.

Top module: `sflash_guard`

## Requirements
- R1: A set-status (01h), program (02h) or sector erase (D8h) or whole erase (C7h) command is only executed when the write-arm latch (status bit 1) was set before the frame ended.
- R2: Reset clears every status bit. Opcode 06h sets the write-arm latch and opcode 04h clears it, both on a frame of at least 8 bits.
- R3: A modifying command is dropped unless its frame holds a multiple of eight bits. Set-status also needs at least 16 bits, and program or sector erase at least 32. A dropped command leaves the latch unchanged.
- R4: An accepted command gives `exec_valid` for one cycle, in the cycle after chip select rises. `exec_kind` carries the code: 1 set-status, 2 program, 3 sector erase, 4 whole erase. From that cycle busy (status bit 0) is high for exactly T cycles, where T is the parameter for that command. The write-arm latch clears in the cycle busy falls.
- R5: While busy, every command except read-status (05h) is ignored, including 04h and 06h.
- R6: An accepted set-status copies payload bit 7 into the lock bit (status bit 7) and payload bits 3:2 into the guard level (status bits 3:2).
- R7: Guard level 3 refuses program, sector erase and whole erase. Levels 1 and 2 refuse only whole erase. Level 0 refuses none.
- R8: While the lock bit is 1 and `wp_n` is low, set-status is refused and the lock bit and guard level stay unchanged. With `wp_n` high it is accepted.
- R9: Opcode B9h enters sleep. In sleep every command, read-status included, is ignored except ABh, which leaves sleep.
- R10: The status byte is {lock, 0, 0, 0, guard[1:0], arm, busy}. After opcode 05h, `sdo` presents bit 7 first and advances one bit per `bit_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cs_n | input | 1 | Chip select, active low; frame ends on rise |
| bit_en | input | 1 | One-cycle marker of a serial bit |
| sdi | input | 1 | Serial data in, MSB first |
| wp_n | input | 1 | Hardware write-protect, active low |
| sdo | output | 1 | Serial status data out |
| exec_valid | output | 1 | Execute strobe for an accepted command |
| exec_kind | output | 3 | Accepted command code |
| status | output | 8 | Live status byte |

## Verification
A command decision is due one clock after the edge that first sees `cs_n` high. The tasks raise `cs_n` at a falling edge and sample `exec_valid`, `exec_kind` and `status` at the next falling edge. Busy is counted in falling edges from that same sample, so a count equal to the command's T shows the full duration with no extra cycle. Each serial status bit is read at the falling edge before the `bit_en` pulse that advances it. The frame tasks keep `bit_en` low between bits, so each bit takes two cycles.

// File: rtl/sfg_pkg.sv
package sfg_pkg;
    localparam logic [7:0] OP_ARM    = 8'h06;
    localparam logic [7:0] OP_DISARM = 8'h04;
    localparam logic [7:0] OP_SETSR  = 8'h01;
    localparam logic [7:0] OP_PROG   = 8'h02;
    localparam logic [7:0] OP_ERSEC  = 8'hD8;
    localparam logic [7:0] OP_ERALL  = 8'hC7;
    localparam logic [7:0] OP_SLEEP  = 8'hB9;
    localparam logic [7:0] OP_WAKE   = 8'hAB;
    localparam logic [7:0] OP_RDSTAT = 8'h05;

    typedef enum logic [2:0] {
        K_NONE  = 3'd0,
        K_SETSR = 3'd1,
        K_PROG  = 3'd2,
        K_ERSEC = 3'd3,
        K_ERALL = 3'd4
    } kind_e;
endpackage

// File: rtl/sfg_frame.sv
module sfg_frame #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             bit_en,
    input  logic             sdi,
    output logic [CNT_W-1:0] bit_cnt,
    output logic [7:0]       opcode,
    output logic [7:0]       payload,
    output logic [7:0]       op_now,
    output logic             op_stb,
    output logic             frame_end
);
    typedef struct packed {
        logic             cs;
        logic [CNT_W-1:0] cnt;
        logic [7:0]       sh;
        logic [7:0]       op;
        logic [7:0]       dat;
    } frm_t;

    frm_t frm_d, frm_q;

    always_comb begin
        frm_d    = frm_q;
        frm_d.cs = cs_n;
        if (cs_n) begin
            frm_d.cnt = '0;
        end else if (bit_en) begin
            frm_d.sh = {frm_q.sh[6:0], sdi};
            if (frm_q.cnt != '1) frm_d.cnt = frm_q.cnt + 1'b1;
            if (frm_q.cnt == CNT_W'(7))  frm_d.op  = {frm_q.sh[6:0], sdi};
            if (frm_q.cnt == CNT_W'(15)) frm_d.dat = {frm_q.sh[6:0], sdi};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            frm_q <= '{cs: 1'b1, cnt: '0, sh: '0, op: '0, dat: '0};
        end else begin
            frm_q <= frm_d;
        end
    end

    assign bit_cnt   = frm_q.cnt;
    assign opcode    = frm_q.op;
    assign payload   = frm_q.dat;
    assign op_now    = {frm_q.sh[6:0], sdi};
    assign op_stb    = !cs_n && bit_en && (frm_q.cnt == CNT_W'(7));
    assign frame_end = cs_n && !frm_q.cs;
endmodule

// File: rtl/sfg_gate.sv
module sfg_gate
    import sfg_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             frame_end,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic [7:0]       opcode,
    input  logic             arm,
    input  logic             busy,
    input  logic             asleep,
    input  logic [1:0]       guard,
    input  logic             lock,
    input  logic             wp_n,
    output kind_e            kind,
    output logic             set_arm,
    output logic             clr_arm,
    output logic             go_sleep,
    output logic             wake
);
    logic whole, has_op, len16, len32, hw_lock;

    assign whole   = (bit_cnt[2:0] == 3'd0);
    assign has_op  = (bit_cnt >= CNT_W'(8));
    assign len16   = (bit_cnt >= CNT_W'(16));
    assign len32   = (bit_cnt >= CNT_W'(32));
    assign hw_lock = lock && !wp_n;

    always_comb begin
        kind     = K_NONE;
        set_arm  = 1'b0;
        clr_arm  = 1'b0;
        go_sleep = 1'b0;
        wake     = 1'b0;
        if (frame_end && has_op) begin
            if (asleep) begin
                if (opcode == OP_WAKE) wake = 1'b1;
            end else if (!busy) begin
                case (opcode)
                    OP_ARM:    set_arm  = 1'b1;
                    OP_DISARM: clr_arm  = 1'b1;
                    OP_SLEEP:  go_sleep = 1'b1;
                    OP_SETSR:  if (arm && whole && len16 && !hw_lock) kind = K_SETSR;
                    OP_PROG:   if (arm && whole && len32 && guard != 2'b11) kind = K_PROG;
                    OP_ERSEC:  if (arm && whole && len32 && guard != 2'b11) kind = K_ERSEC;
                    OP_ERALL:  if (arm && whole && guard == 2'b00) kind = K_ERALL;
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/sfg_timer.sv
module sfg_timer
    import sfg_pkg::*;
#(
    parameter int T_SETSR = 40,
    parameter int T_PROG  = 30,
    parameter int T_ERSEC = 60,
    parameter int T_ERALL = 80
) (
    input  logic  clk,
    input  logic  rst_n,
    input  kind_e start,
    output logic  busy,
    output logic  done
);
    localparam int T_MAX1 = (T_SETSR > T_PROG) ? T_SETSR : T_PROG;
    localparam int T_MAX2 = (T_ERSEC > T_ERALL) ? T_ERSEC : T_ERALL;
    localparam int T_MAX  = (T_MAX1 > T_MAX2) ? T_MAX1 : T_MAX2;
    localparam int TW     = $clog2(T_MAX + 1);

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        case (start)
            K_SETSR: tmr_d.cnt = TW'(T_SETSR);
            K_PROG:  tmr_d.cnt = TW'(T_PROG);
            K_ERSEC: tmr_d.cnt = TW'(T_ERSEC);
            K_ERALL: tmr_d.cnt = TW'(T_ERALL);
            default: if (tmr_q.cnt != '0) tmr_d.cnt = tmr_q.cnt - 1'b1;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = (tmr_q.cnt != '0);
    assign done = (tmr_q.cnt == TW'(1));
endmodule

// File: rtl/sflash_guard.sv
module sflash_guard
    import sfg_pkg::*;
#(
    parameter int CNT_W   = 12,
    parameter int T_SETSR = 40,
    parameter int T_PROG  = 30,
    parameter int T_ERSEC = 60,
    parameter int T_ERALL = 80
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       bit_en,
    input  logic       sdi,
    input  logic       wp_n,
    output logic       sdo,
    output logic       exec_valid,
    output logic [2:0] exec_kind,
    output logic [7:0] status
);
    typedef struct packed {
        logic       arm;
        logic       asleep;
        logic       lock;
        logic [1:0] guard;
        logic       exv;
        logic [2:0] exk;
        logic       rd_on;
        logic [7:0] rd_sh;
    } top_t;

    top_t cur_d, cur_q;

    logic [CNT_W-1:0] bit_cnt;
    logic [7:0]       opcode, payload, op_now;
    logic             op_stb, frame_end;
    kind_e            kind;
    logic             set_arm, clr_arm, go_sleep, wake;
    logic             busy, done;
    logic             in_sleep;
    logic [2:0]       unused_payload;

    sfg_frame #(.CNT_W(CNT_W)) u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .bit_en    (bit_en),
        .sdi       (sdi),
        .bit_cnt   (bit_cnt),
        .opcode    (opcode),
        .payload   (payload),
        .op_now    (op_now),
        .op_stb    (op_stb),
        .frame_end (frame_end)
    );

    sfg_gate #(.CNT_W(CNT_W)) u_gate (
        .frame_end (frame_end),
        .bit_cnt   (bit_cnt),
        .opcode    (opcode),
        .arm       (cur_q.arm),
        .busy      (busy),
        .asleep    (cur_q.asleep),
        .guard     (cur_q.guard),
        .lock      (cur_q.lock),
        .wp_n      (wp_n),
        .kind      (kind),
        .set_arm   (set_arm),
        .clr_arm   (clr_arm),
        .go_sleep  (go_sleep),
        .wake      (wake)
    );

    sfg_timer #(
        .T_SETSR (T_SETSR),
        .T_PROG  (T_PROG),
        .T_ERSEC (T_ERSEC),
        .T_ERALL (T_ERALL)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (kind),
        .busy  (busy),
        .done  (done)
    );

    assign status         = {cur_q.lock, 3'b000, cur_q.guard, cur_q.arm, busy};
    assign unused_payload = payload[6:4] ^ {1'b0, payload[1:0]};

    always_comb begin
        cur_d     = cur_q;
        cur_d.exv = (kind != K_NONE);
        cur_d.exk = kind;

        if (set_arm)         cur_d.arm = 1'b1;
        if (clr_arm || done) cur_d.arm = 1'b0;

        if (kind == K_SETSR) begin
            cur_d.lock  = payload[7];
            cur_d.guard = payload[3:2];
        end

        if (go_sleep) cur_d.asleep = 1'b1;
        if (wake)     cur_d.asleep = 1'b0;

        if (cs_n) begin
            cur_d.rd_on = 1'b0;
        end else if (op_stb && op_now == OP_RDSTAT && !cur_q.asleep) begin
            cur_d.rd_on = 1'b1;
            cur_d.rd_sh = status;
        end else if (bit_en && cur_q.rd_on) begin
            if (bit_cnt[2:0] == 3'd7) cur_d.rd_sh = status;
            else                      cur_d.rd_sh = {cur_q.rd_sh[6:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign sdo        = cur_q.rd_on && cur_q.rd_sh[7];
    assign exec_valid = cur_q.exv;
    assign exec_kind  = cur_q.exk;
    assign in_sleep   = cur_q.asleep;
endmodule

// File: rtl/sflash_guard_chk.sv
module sflash_guard_chk #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wp_n,
    input logic             exec_valid,
    input logic [2:0]       exec_kind,
    input logic [7:0]       status,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             in_sleep
);
    logic [2:0] unused_stat;
    assign unused_stat = status[6:4];

    // R1
    p_arm_needed_r1: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> $past(status[1]));

    // R3
    p_whole_bytes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> ($past(bit_cnt[2:0]) == 3'd0));

    // R4
    p_exec_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> status[0]);

    // R4
    p_arm_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[0]) |-> !status[1]);

    // R5
    p_busy_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |-> !$past(status[0]));

    // R7
    p_full_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_kind != 3'd1) |-> ($past(status[3:2]) != 2'b11));

    // R7
    p_erall_guard_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (exec_valid && exec_kind == 3'd4) |-> ($past(status[3:2]) == 2'b00));

    // R8
    p_hw_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (status[7] && !wp_n) |=> $stable({status[7], status[3:2]}));

    // R9
    p_sleep_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_sleep |=> !exec_valid);
endmodule

bind sflash_guard sflash_guard_chk #(.CNT_W(CNT_W)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wp_n       (wp_n),
    .exec_valid (exec_valid),
    .exec_kind  (exec_kind),
    .status     (status),
    .bit_cnt    (bit_cnt),
    .in_sleep   (in_sleep)
);

// File: tb/test_sflash_guard.sv
module test_sflash_guard;
    localparam int T_SETSR = 40;
    localparam int T_PROG  = 30;
    localparam int T_ERSEC = 60;
    localparam int T_ERALL = 80;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       bit_en = 1'b0;
    logic       sdi = 1'b0;
    logic       wp_n = 1'b1;
    logic       sdo;
    logic       exec_valid;
    logic [2:0] exec_kind;
    logic [7:0] status;

    int   n_run = 0;
    int   n_bad = 0;
    bit   ended = 1'b0;
    logic got_v;
    logic [2:0] got_k;

    always #2.5 clk = ~clk;

    sflash_guard #(
        .T_SETSR (T_SETSR),
        .T_PROG  (T_PROG),
        .T_ERSEC (T_ERSEC),
        .T_ERALL (T_ERALL)
    ) i_sflash_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .bit_en     (bit_en),
        .sdi        (sdi),
        .wp_n       (wp_n),
        .sdo        (sdo),
        .exec_valid (exec_valid),
        .exec_kind  (exec_kind),
        .status     (status)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        sdi    = b;
        bit_en = 1'b1;
        @(negedge clk);
        bit_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic frame(input logic [39:0] v, input int n);
        cs_n = 1'b0;
        @(negedge clk);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
        cs_n = 1'b1;
        @(negedge clk);
        got_v = exec_valid;
        got_k = exec_kind;
    endtask

    task automatic wait_idle();
        while (status[0]) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic read_stat(output logic [7:0] v);
        cs_n = 1'b0;
        @(negedge clk);
        for (int i = 7; i >= 0; i--) send_bit(8'h05 >> i);
        for (int i = 7; i >= 0; i--) begin
            v[i] = sdo;
            send_bit(1'b0);
        end
        cs_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R2 reset status", status, 8'h00);
        check("R4 reset exec", exec_valid, 1'b0);
        check("R10 reset sdo", sdo, 1'b0);
    endtask

    task automatic t_arm();
        frame(40'h02000100, 32);
        check("R1 program without arm", got_v, 1'b0);
        frame(40'h06, 8);
        check("R2 arm sets bit1", status, 8'h02);
        frame(40'h04, 8);
        check("R2 disarm clears bit1", status, 8'h00);
    endtask

    task automatic t_count_busy();
        int n;
        frame(40'h06, 8);
        frame(40'h020, 12);
        check("R3 12-bit program dropped", got_v, 1'b0);
        check("R3 arm kept after drop", status[1], 1'b1);
        frame(40'h02000100, 32);
        check("R4 program strobe", got_v, 1'b1);
        check("R4 program kind", got_k, 3'd2);
        n = 0;
        while (status[0]) begin
            n++;
            @(negedge clk);
        end
        check("R4 program busy cycles", n, T_PROG);
        check("R4 arm cleared at end", status[1], 1'b0);
    endtask

    task automatic t_busy_block();
        frame(40'h06, 8);
        frame(40'hD8000000, 32);
        check("R4 sector erase kind", got_k, 3'd3);
        frame(40'h04, 8);
        check("R5 disarm ignored while busy", status[1:0], 2'b11);
        wait_idle();
        check("R5 arm cleared only by completion", status, 8'h00);
    endtask

    task automatic set_stat(input logic [7:0] v);
        frame(40'h06, 8);
        frame({24'h0, 8'h01, v}, 16);
        wait_idle();
    endtask

    task automatic t_guard();
        set_stat(8'h04);
        check("R6 guard level 1 written", status, 8'h04);
        frame(40'h06, 8);
        frame(40'hC7, 8);
        check("R7 whole erase refused at level 1", got_v, 1'b0);
        frame(40'hD8000000, 32);
        check("R7 sector erase allowed at level 1", got_k, 3'd3);
        wait_idle();
        set_stat(8'h0C);
        check("R6 guard level 3 written", status, 8'h0C);
        frame(40'h06, 8);
        frame(40'h02000100, 32);
        check("R7 program refused at level 3", got_v, 1'b0);
        frame(40'hD8000000, 32);
        check("R7 sector erase refused at level 3", got_v, 1'b0);
        frame(40'hC7, 8);
        check("R7 whole erase refused at level 3", got_v, 1'b0);
        frame(40'h0100, 16);
        wait_idle();
        check("R6 guard cleared", status, 8'h00);
        frame(40'h06, 8);
        frame(40'hC7, 8);
        check("R7 whole erase at level 0", got_k, 3'd4);
        wait_idle();
    endtask

    task automatic t_hw_lock();
        set_stat(8'h88);
        check("R6 lock and level 2", status, 8'h88);
        wp_n = 1'b0;
        frame(40'h06, 8);
        frame(40'h0100, 16);
        check("R8 set-status refused", got_v, 1'b0);
        check("R8 bits kept", status, 8'h8A);
        wp_n = 1'b1;
        frame(40'h0100, 16);
        check("R8 accepted with pin high", got_k, 3'd1);
        wait_idle();
        check("R8 bits cleared", status, 8'h00);
    endtask

    task automatic t_sleep();
        logic [7:0] r;
        frame(40'hB9, 8);
        frame(40'h06, 8);
        check("R9 arm ignored in sleep", status, 8'h00);
        read_stat(r);
        check("R9 read ignored in sleep", r, 8'h00);
        frame(40'hAB, 8);
        frame(40'h06, 8);
        check("R9 arm works after wake", status, 8'h02);
    endtask

    task automatic t_read();
        logic [7:0] r;
        set_stat(8'h8C);
        frame(40'h06, 8);
        read_stat(r);
        check("R10 serial status", r, 8'h8E);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_arm();
        t_count_busy();
        t_busy_block();
        t_guard();
        t_hw_lock();
        t_sleep();
        t_read();
        if (!ended) begin
            ended = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_run++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_bad);
            $finish;
        end
    end
endmodule